// File: doc/BRIEF.md
# Configuration Access Bridge

This block sits at the front of a host bridge. It converts processor I/O-port cycles into configuration-space requests for the downstream fabric. It supports two legacy access schemes, and only one of them is live at a time.

In the first scheme, software loads a 32-bit address register at port 0xCF8. That register holds an enable bit and the bus, device, function and dword-register fields. Software then moves data through the four-byte window at 0xCFC–0xCFF. In the second scheme, software sets a function/enable byte and a bus byte. It then reaches configuration space directly through the I/O range 0xC000–0xCFFF. The register at 0xCF8 reads back exactly what was written to it, so software can probe for either scheme. A select byte at 0xCFB picks the live scheme, and its reset value comes from a strap pin.

The processor side uses a valid/ready handshake. The master raises `io_valid` and holds the address, byte enables, direction and write data steady until `io_ready` pulses for one cycle. Read data is valid on `io_rdata` in that same cycle. The master must drop `io_valid` or present a new request after the pulse.

The downstream request side also uses valid/ready. `cfg_valid` and every request field stay stable until the cycle in which `cfg_ready` is high. The responder then returns `cfg_rsp_valid` with `cfg_rsp_data` at least one cycle after acceptance. The bridge always accepts the response, so the response side has no back-pressure. Every forwarded access receives a response, including writes.

Top module: `cfg_access_bridge`

## Requirements
- R1: After reset, `io_ready` and `cfg_valid` are low. The 32-bit address register reads 0, and the function/enable byte and bus byte read 0. The select byte reads 0x01 when `strap_mech1` was high during reset, and 0x00 otherwise.
- R2: A transfer at dword 0xCF8 with all four byte enables set reads or writes the 32-bit address register. A read returns the last value written, except that bits 1:0 always read 0.
- R3: When the select byte's bit 0 is 1, an access to dword 0xCFC with address-register bit 31 set is forwarded downstream. The fields come from the address register: bus from bits 23:16, device from bits 15:11, function from bits 10:8 and register from bits 7:2. The byte enables, direction and write data pass through unchanged.
- R4: In the scheme chosen by select bit 0 = 1, a dword-0xCFC access made while address-register bit 31 is clear produces no request. Such a read returns 0xFFFFFFFF and such a write is dropped.
- R5: A transfer at dword 0xCF8 with partial byte enables reaches byte registers, one per lane. Lane 0 (0xCF8) is the function/enable byte, lane 2 (0xCFA) is the bus byte and lane 3 (0xCFB) is the select byte. Lane 1 reads 0xFF and ignores writes. None of these byte writes alters the 32-bit address register.
- R6: Bit 0 of the select byte chooses the live scheme: 1 selects the address-register scheme and 0 selects the direct-window scheme. After writing 0 to the select byte, the function/enable byte and the bus byte, the select byte and the function/enable byte both read 0x00.
- R7: When select bit 0 is 0 and bits 7:4 of the function/enable byte equal 0xF, any access in 0xC000–0xCFFF other than dword 0xCF8 is forwarded. The device is address bits 11:8 with device bit 4 at 0, the register is address bits 7:2, the function is function/enable bits 3:1 and the bus is the bus byte.
- R8: In the direct-window scheme, a window access made while function/enable bits 7:4 are not 0xF produces no request. Such a read returns 0xFFFFFFFF.
- R9: An address claimed by neither the live scheme nor the port registers completes without a request. A read of such an address returns 0xFFFFFFFF.
- R10: `cfg_valid` and its fields stay stable until `cfg_ready` is high. For a forwarded access, `io_ready` does not rise until `cfg_rsp_valid` has been seen, and read data equals `cfg_rsp_data`.
- R11: `io_ready` is high for exactly one cycle per transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_mech1 | input | 1 | Reset value of select bit 0 (1 selects the address-register scheme) |
| io_valid | input | 1 | Processor I/O request valid |
| io_ready | output | 1 | Transfer complete, one-cycle pulse |
| io_addr | input | 16 | I/O byte address; bits 1:0 are ignored |
| io_be | input | 4 | Byte enables, lane n = byte n of the dword |
| io_we | input | 1 | 1 = write |
| io_wdata | input | 32 | Write data, lane aligned |
| io_rdata | output | 32 | Read data, valid while io_ready is high |
| cfg_valid | output | 1 | Downstream request valid |
| cfg_ready | input | 1 | Downstream request accepted |
| cfg_bus | output | 8 | Bus number |
| cfg_dev | output | 5 | Device number |
| cfg_func | output | 3 | Function number |
| cfg_reg | output | 6 | Dword register index |
| cfg_be | output | 4 | Byte enables |
| cfg_we | output | 1 | 1 = write |
| cfg_wdata | output | 32 | Write data |
| cfg_rsp_valid | input | 1 | Downstream response valid |
| cfg_rsp_data | input | 32 | Downstream response data |

## Verification
The bench builds the bridge with its default parameters. This gives the all-ones fill value for unclaimed and disabled reads, and the standard 8/5/3/6 field widths.

The bench resets the block once with each strap value, so both schemes are reachable from reset. It also switches between the schemes at run time through the select byte, which brings the probe sequences for each scheme and the unclaimed-address paths of both within reach. The downstream responder holds off acceptance for one cycle on every request, so the request-hold rule is exercised on every forwarded access.

// File: rtl/cab_pkg.sv
package cab_pkg;
  localparam int AW     = 16;
  localparam int DW     = 32;
  localparam int BEW    = DW / 8;
  localparam int BUS_W  = 8;
  localparam int DEV_W  = 5;
  localparam int FN_W   = 3;
  localparam int REG_W  = 6;
  localparam int DWA_W  = AW - 2;

  localparam logic [DWA_W-1:0] PORT_DW = DWA_W'(16'hCF8 >> 2);
  localparam logic [DWA_W-1:0] WIN1_DW = DWA_W'(16'hCFC >> 2);
  localparam logic [3:0]       WIN2_NIB = 4'hC;
  localparam logic [3:0]       M2_ON    = 4'hF;

  typedef enum logic [1:0] {ACC_REG, ACC_CFG, ACC_VOID} acc_kind_e;
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_RSP, S_DONE} cab_state_e;

  typedef struct packed {
    logic [BUS_W-1:0] bus;
    logic [DEV_W-1:0] dev;
    logic [FN_W-1:0]  fn;
    logic [REG_W-1:0] rg;
    logic [BEW-1:0]   be;
    logic             we;
    logic [DW-1:0]    wdata;
  } cfg_req_t;
endpackage

// File: rtl/cab_regs.sv
module cab_regs
  import cab_pkg::*;
#(
  parameter logic [BEW-1:0] LANE_KEEP = 4'b1101
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           strap_mech1,
  input  logic           wr_en,
  input  logic [BEW-1:0] be,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  addr_q,
  output logic [DW-1:0]  lanes_q,
  output logic [DW-1:0]  rd_data
);
  localparam logic [BEW-1:0] FULL = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)
      addr_q <= '0;
    else if (wr_en && be == FULL)
      addr_q <= {wdata[DW-1:2], 2'b00};
  end

  for (genvar l = 0; l < BEW; l++) begin : g_lane
    if (LANE_KEEP[l]) begin : g_reg
      logic [7:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n)
          q <= (l == BEW - 1) ? {7'd0, strap_mech1} : 8'h00;
        else if (wr_en && be != FULL && be[l])
          q <= wdata[8*l +: 8];
      end
      assign lanes_q[8*l +: 8] = q;
    end else begin : g_void
      assign lanes_q[8*l +: 8] = 8'hFF;
    end
  end

  assign rd_data = (be == FULL) ? addr_q : lanes_q;
endmodule

// File: rtl/cab_decode.sv
module cab_decode
  import cab_pkg::*;
(
  input  logic [AW-1:0]  io_addr,
  input  logic [BEW-1:0] io_be,
  input  logic           io_we,
  input  logic [DW-1:0]  io_wdata,
  input  logic [DW-1:0]  addr_q,
  input  logic [7:0]     fe_q,
  input  logic [7:0]     bus_q,
  input  logic           mech1,
  output acc_kind_e      kind,
  output cfg_req_t       req
);
  logic is_port, m1_hit, m2_hit, m1_en, m2_en;

  assign is_port = io_addr[AW-1:2] == PORT_DW;
  assign m1_hit  = io_addr[AW-1:2] == WIN1_DW;
  assign m2_hit  = io_addr[AW-1:AW-4] == WIN2_NIB;
  assign m1_en   = addr_q[DW-1];
  assign m2_en   = fe_q[7:4] == M2_ON;

  always_comb begin
    if (is_port)
      kind = ACC_REG;
    else if (mech1)
      kind = (m1_hit && m1_en) ? ACC_CFG : ACC_VOID;
    else
      kind = (m2_hit && m2_en) ? ACC_CFG : ACC_VOID;
  end

  always_comb begin
    req.be    = io_be;
    req.we    = io_we;
    req.wdata = io_wdata;
    if (mech1) begin
      req.bus = addr_q[23:16];
      req.dev = addr_q[15:11];
      req.fn  = addr_q[10:8];
      req.rg  = addr_q[7:2];
    end else begin
      req.bus = bus_q;
      req.dev = {1'b0, io_addr[11:8]};
      req.fn  = fe_q[3:1];
      req.rg  = io_addr[7:2];
    end
  end
endmodule

// File: rtl/cab_ctrl.sv
module cab_ctrl
  import cab_pkg::*;
#(
  parameter logic [DW-1:0] VOID_DATA = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          io_valid,
  input  acc_kind_e     kind,
  input  cfg_req_t      req_in,
  input  logic [DW-1:0] reg_rd,
  input  logic          cfg_ready,
  input  logic          cfg_rsp_valid,
  input  logic [DW-1:0] cfg_rsp_data,
  output logic          reg_wr_en,
  output logic          io_ready,
  output logic [DW-1:0] io_rdata,
  output logic          cfg_valid,
  output cfg_req_t      req_q
);
  cab_state_e st;

  assign reg_wr_en = (st == S_IDLE) && io_valid && (kind == ACC_REG) && req_in.we;
  assign io_ready  = st == S_DONE;
  assign cfg_valid = st == S_REQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      io_rdata <= '0;
      req_q    <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (io_valid) begin
          unique case (kind)
            ACC_REG: begin io_rdata <= reg_rd; st <= S_DONE; end
            ACC_CFG: begin req_q <= req_in; st <= S_REQ; end
            default: begin io_rdata <= VOID_DATA; st <= S_DONE; end
          endcase
        end
        S_REQ: if (cfg_ready) st <= S_RSP;
        S_RSP: if (cfg_rsp_valid) begin
          io_rdata <= cfg_rsp_data;
          st       <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_access_bridge.sv
module cfg_access_bridge
  import cab_pkg::*;
#(
  parameter logic [DW-1:0] VOID_DATA = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_mech1,
  input  logic              io_valid,
  output logic              io_ready,
  input  logic [AW-1:0]     io_addr,
  input  logic [BEW-1:0]    io_be,
  input  logic              io_we,
  input  logic [DW-1:0]     io_wdata,
  output logic [DW-1:0]     io_rdata,
  output logic              cfg_valid,
  input  logic              cfg_ready,
  output logic [BUS_W-1:0]  cfg_bus,
  output logic [DEV_W-1:0]  cfg_dev,
  output logic [FN_W-1:0]   cfg_func,
  output logic [REG_W-1:0]  cfg_reg,
  output logic [BEW-1:0]    cfg_be,
  output logic              cfg_we,
  output logic [DW-1:0]     cfg_wdata,
  input  logic              cfg_rsp_valid,
  input  logic [DW-1:0]     cfg_rsp_data
);
  logic [DW-1:0] addr_q, lanes_q, reg_rd;
  logic          reg_wr_en, mech1, f2_en;
  acc_kind_e     kind;
  cfg_req_t      req_in, req_q;

  assign mech1 = lanes_q[24];
  assign f2_en = lanes_q[7:4] == M2_ON;

  cab_regs u_regs (
    .clk(clk), .rst_n(rst_n), .strap_mech1(strap_mech1),
    .wr_en(reg_wr_en), .be(io_be), .wdata(io_wdata),
    .addr_q(addr_q), .lanes_q(lanes_q), .rd_data(reg_rd)
  );

  cab_decode u_dec (
    .io_addr(io_addr), .io_be(io_be), .io_we(io_we), .io_wdata(io_wdata),
    .addr_q(addr_q), .fe_q(lanes_q[7:0]), .bus_q(lanes_q[23:16]),
    .mech1(mech1), .kind(kind), .req(req_in)
  );

  cab_ctrl #(.VOID_DATA(VOID_DATA)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .kind(kind),
    .req_in(req_in), .reg_rd(reg_rd), .cfg_ready(cfg_ready),
    .cfg_rsp_valid(cfg_rsp_valid), .cfg_rsp_data(cfg_rsp_data),
    .reg_wr_en(reg_wr_en), .io_ready(io_ready), .io_rdata(io_rdata),
    .cfg_valid(cfg_valid), .req_q(req_q)
  );

  assign cfg_bus   = req_q.bus;
  assign cfg_dev   = req_q.dev;
  assign cfg_func  = req_q.fn;
  assign cfg_reg   = req_q.rg;
  assign cfg_be    = req_q.be;
  assign cfg_we    = req_q.we;
  assign cfg_wdata = req_q.wdata;
endmodule

// File: rtl/cab_checker.sv
module cab_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        io_ready,
  input logic        cfg_valid,
  input logic        cfg_ready,
  input logic [7:0]  cfg_bus,
  input logic [4:0]  cfg_dev,
  input logic [5:0]  cfg_reg,
  input logic [31:0] cfg_wdata,
  input logic        mech1,
  input logic        m1_en,
  input logic        m2_en
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && !cfg_ready |=> cfg_valid && $stable(cfg_bus) && $stable(cfg_reg) && $stable(cfg_wdata)); // R10
  AST_NO_EARLY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> !io_ready); // R10
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    io_ready |=> !io_ready); // R11
  AST_M1_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_valid) && mech1 |-> m1_en); // R4
  AST_M2_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_valid) && !mech1 |-> m2_en); // R8
  AST_M2_DEV_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && !mech1 |-> !cfg_dev[4]); // R7
endmodule

bind cfg_access_bridge cab_checker u_chk (
  .clk(clk), .rst_n(rst_n), .io_ready(io_ready), .cfg_valid(cfg_valid),
  .cfg_ready(cfg_ready), .cfg_bus(cfg_bus), .cfg_dev(cfg_dev),
  .cfg_reg(cfg_reg), .cfg_wdata(cfg_wdata), .mech1(mech1),
  .m1_en(addr_q[31]), .m2_en(f2_en)
);

// File: tb/sim_cfg_access_bridge.sv
module sim_cfg_access_bridge;
  localparam time TCLK = 10ns;

  logic        clk = 0, rst_n = 0, strap_mech1 = 1;
  logic        io_valid = 0, io_we = 0;
  logic [15:0] io_addr = '0;
  logic [3:0]  io_be = '0;
  logic [31:0] io_wdata = '0;
  logic        io_ready;
  logic [31:0] io_rdata;
  logic        cfg_valid, cfg_we;
  logic        cfg_ready = 0, cfg_rsp_valid = 0;
  logic [31:0] cfg_rsp_data = '0, cfg_wdata;
  logic [7:0]  cfg_bus;
  logic [4:0]  cfg_dev;
  logic [2:0]  cfg_func;
  logic [5:0]  cfg_reg;
  logic [3:0]  cfg_be;

  int compared = 0, mismatched = 0;
  logic [58:0] exp_q[$];

  always #(TCLK/2) clk = ~clk;

  cfg_access_bridge u0 (
    .clk(clk), .rst_n(rst_n), .strap_mech1(strap_mech1),
    .io_valid(io_valid), .io_ready(io_ready), .io_addr(io_addr),
    .io_be(io_be), .io_we(io_we), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_bus(cfg_bus),
    .cfg_dev(cfg_dev), .cfg_func(cfg_func), .cfg_reg(cfg_reg),
    .cfg_be(cfg_be), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rsp_valid(cfg_rsp_valid), .cfg_rsp_data(cfg_rsp_data)
  );

  function automatic logic [31:0] rsp_of(logic [7:0] b, logic [4:0] d, logic [2:0] f, logic [5:0] r);
    return {3'b0, b, 3'b0, d, 2'b0, f, 2'b0, r} ^ 32'hA500_005A;
  endfunction

  function automatic logic [31:0] m1_addr(logic en, logic [7:0] b, logic [4:0] d, logic [2:0] f, logic [5:0] r);
    return {en, 7'd0, b, d, f, r, 2'b00};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic expect_req(logic [7:0] b, logic [4:0] d, logic [2:0] f, logic [5:0] r,
                            logic [3:0] be, logic we, logic [31:0] wd);
    exp_q.push_back({b, d, f, r, be, we, wd});
  endtask

  // downstream responder and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (cfg_valid) begin
        @(negedge clk);
        cfg_ready = 1;
        compared++;
        if (exp_q.size() == 0) begin
          mismatched++;
          $display("FAIL R3/R7: unexpected request actual %h expected none",
                   {cfg_bus, cfg_dev, cfg_func, cfg_reg, cfg_be, cfg_we, cfg_wdata});
        end else begin
          logic [58:0] e;
          e = exp_q.pop_front();
          if (e !== {cfg_bus, cfg_dev, cfg_func, cfg_reg, cfg_be, cfg_we, cfg_wdata}) begin
            mismatched++;
            $display("FAIL R3/R7: request actual %h expected %h",
                     {cfg_bus, cfg_dev, cfg_func, cfg_reg, cfg_be, cfg_we, cfg_wdata}, e);
          end
        end
        cfg_rsp_data = rsp_of(cfg_bus, cfg_dev, cfg_func, cfg_reg);
        @(negedge clk);
        cfg_ready = 0;
        @(negedge clk);
        cfg_rsp_valid = 1;
        @(negedge clk);
        cfg_rsp_valid = 0;
      end
    end
  end

  task automatic xfer(logic [15:0] a, logic [3:0] be, logic we, logic [31:0] wd,
                      output logic [31:0] rd);
    int guard;
    @(negedge clk);
    io_addr = a; io_be = be; io_we = we; io_wdata = wd; io_valid = 1;
    guard = 0;
    do begin
      @(posedge clk); #1;
      guard++;
    end while (!io_ready && guard < 50);
    rd = io_rdata;
    io_valid = 0;
    @(posedge clk); #1;
    chk("R11 ready pulse", {31'd0, io_ready}, 32'd0);
  endtask

  task automatic do_reset(logic strap);
    @(negedge clk);
    rst_n = 0; strap_mech1 = strap;
    repeat (3) @(negedge clk);
    chk("R1 io_ready in reset", {31'd0, io_ready}, 32'd0);
    chk("R1 cfg_valid in reset", {31'd0, cfg_valid}, 32'd0);
    rst_n = 1;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    do_reset(1'b1);
    xfer(16'hCF8, 4'hF, 0, 0, rd);             chk("R1 addr reg reset", rd, 32'h0);
    xfer(16'hCF8, 4'h1, 0, 0, rd);             chk("R1 func/enable reset", {24'd0, rd[7:0]}, 32'h0);
    xfer(16'hCFB, 4'h8, 0, 0, rd);             chk("R1 select byte strap=1", {24'd0, rd[31:24]}, 32'h01);

    // R2 address register probe and low bits
    xfer(16'hCF8, 4'hF, 1, 32'h8000_0000, rd);
    xfer(16'hCF8, 4'hF, 0, 0, rd);             chk("R2 probe readback", rd, 32'h8000_0000);
    xfer(16'hCF8, 4'hF, 1, 32'h8012_3457, rd);
    xfer(16'hCF8, 4'hF, 0, 0, rd);             chk("R2 low bits zero", rd, 32'h8012_3454);

    // R3 forwarded dword read and byte write
    xfer(16'hCF8, 4'hF, 1, m1_addr(1, 8'h12, 5'h1B, 3'd6, 6'h0F), rd);
    expect_req(8'h12, 5'h1B, 3'd6, 6'h0F, 4'hF, 0, 32'h0);
    xfer(16'hCFC, 4'hF, 0, 32'h0, rd);         chk("R3 read data", rd, rsp_of(8'h12, 5'h1B, 3'd6, 6'h0F));
    expect_req(8'h12, 5'h1B, 3'd6, 6'h0F, 4'h4, 1, 32'h00AB_0000);
    xfer(16'hCFE, 4'h4, 1, 32'h00AB_0000, rd);

    // R4 disabled window
    xfer(16'hCF8, 4'hF, 1, m1_addr(0, 8'h12, 5'h1B, 3'd6, 6'h0F), rd);
    xfer(16'hCFC, 4'hF, 0, 0, rd);             chk("R4 disabled read", rd, 32'hFFFF_FFFF);
    xfer(16'hCFC, 4'hF, 1, 32'h1111_2222, rd);

    // R9 unclaimed in address-register scheme
    xfer(16'hC104, 4'hF, 0, 0, rd);            chk("R9 unclaimed m1", rd, 32'hFFFF_FFFF);

    // R5 byte lanes
    xfer(16'hCF8, 4'hF, 1, 32'h8000_1234, rd);
    xfer(16'hCF9, 4'h2, 1, 32'h0000_5500, rd);
    xfer(16'hCFA, 4'h4, 1, 32'h003C_0000, rd);
    xfer(16'hCF9, 4'h2, 0, 0, rd);             chk("R5 lane1 reads FF", {24'd0, rd[15:8]}, 32'hFF);
    xfer(16'hCFA, 4'h4, 0, 0, rd);             chk("R5 bus byte", {24'd0, rd[23:16]}, 32'h3C);
    xfer(16'hCF8, 4'hF, 0, 0, rd);             chk("R5 addr reg untouched", rd, 32'h8000_1234);

    // R6 direct-window probe
    xfer(16'hCFB, 4'h8, 1, 32'h0, rd);
    xfer(16'hCF8, 4'h1, 1, 32'h0, rd);
    xfer(16'hCFA, 4'h4, 1, 32'h0, rd);
    xfer(16'hCF8, 4'h1, 0, 0, rd);             chk("R6 probe func byte", {24'd0, rd[7:0]}, 32'h0);
    xfer(16'hCFB, 4'h8, 0, 0, rd);             chk("R6 probe select byte", {24'd0, rd[31:24]}, 32'h0);

    // R7 direct window forwarding
    xfer(16'hCF8, 4'h1, 1, 32'h0000_00FA, rd);
    xfer(16'hCFA, 4'h4, 1, 32'h003C_0000, rd);
    expect_req(8'h3C, 5'h07, 3'd5, 6'h29, 4'hF, 0, 32'h0);
    xfer(16'hC7A4, 4'hF, 0, 0, rd);            chk("R7 read data", rd, rsp_of(8'h3C, 5'h07, 3'd5, 6'h29));
    expect_req(8'h3C, 5'h0F, 3'd5, 6'h04, 4'h3, 1, 32'h0000_1234);
    xfer(16'hCF10, 4'h3, 1, 32'h0000_1234, rd);

    // R8 disabled direct window
    xfer(16'hCF8, 4'h1, 1, 32'h0, rd);
    xfer(16'hC7A4, 4'hF, 0, 0, rd);            chk("R8 disabled read", rd, 32'hFFFF_FFFF);
    xfer(16'hD000, 4'hF, 0, 0, rd);            chk("R9 unclaimed m2", rd, 32'hFFFF_FFFF);

    // R6 switch back to the address-register scheme
    xfer(16'hCF8, 4'h1, 1, 32'h0000_00F2, rd);
    xfer(16'hCFB, 4'h8, 1, 32'h0100_0000, rd);
    xfer(16'hCF8, 4'hF, 1, m1_addr(1, 8'h01, 5'h02, 3'd3, 6'h04), rd);
    xfer(16'hC7A4, 4'hF, 0, 0, rd);            chk("R6 window off in m1", rd, 32'hFFFF_FFFF);
    expect_req(8'h01, 5'h02, 3'd3, 6'h04, 4'hF, 0, 32'h0);
    xfer(16'hCFC, 4'hF, 0, 0, rd);             chk("R6 m1 live again", rd, rsp_of(8'h01, 5'h02, 3'd3, 6'h04));

    // R1 strap low
    do_reset(1'b0);
    xfer(16'hCFB, 4'h8, 0, 0, rd);             chk("R1 select byte strap=0", {24'd0, rd[31:24]}, 32'h0);
    xfer(16'hC7A4, 4'hF, 0, 0, rd);            chk("R8 disabled after reset", rd, 32'hFFFF_FFFF);

    repeat (10) @(negedge clk);
    chk("R10 all expected requests seen", exp_q.size(), 0);
    finish_run();
  end
endmodule